// File: doc/BRIEF.md
# Indexed Event Counter Unit

A performance monitoring block with a small bank of wide event counters that all sit behind one shared window of auxiliary registers. Software writes a counter index first. From then on, the count, snapshot and configuration registers act on the counter that index selects. Each counter carries its own condition selector, which picks one line out of a vector of per-cycle condition pulses. Selector code 0 never fires, and that is how a single counter is parked.

A global enable bit starts or stops every counter at once. A clear strobe zeroes the whole bank. A snapshot strobe copies the selected counter into a separate low/high register pair in one clock, so software can read both halves without a carry tearing them. Both count halves are writable so that a counter can be preloaded. Read-only build words tell software whether the unit is present, how many counters it has and how wide they are. A name table returns an 8-character ASCII label for each countable condition, for example `evt05` padded with NUL.

The bus side is a plain single-cycle register port. A write takes effect at the clock edge. Read data is a combinational function of the address and of the registered state, so there is no handshake and no back-pressure on either side. Condition inputs are sampled on every rising clock edge.

Top module: `evctr_unit`

## Requirements
- R1: The counter build word at 0x0F5 reads {ext field (0x00) in [31:24], counter count in [23:16], 6'b0, size code in [9:8], version 0x01 in [7:0]}. The counter width is 32+16*size code bits. With the defaults it reads 0x0004_0101. The condition build word at 0x0F6 reads {condition count in [31:16], 8'b0, version in [7:0]}, which is 0x0010_0001 by default.
- R2: After a write to the condition index at 0x240, name word 0 (0x241) returns characters 0..3 of the condition's name and name word 1 (0x242) returns characters 4..7. Character 0 sits in bits [7:0] of each word. The name is "evt" followed by two decimal digits of the condition number, then NUL bytes. An index at or above the condition count reads 0 in both words.
- R3: The counter index at 0x256 stores bits [7:0] of the write and reads them back. Count low/high (0x250/0x251), snapshot and config (0x254) accesses address only the indexed counter. An index at or above the counter count reads 0 and ignores count and config writes.
- R4: Control bit 0 (0x255) is the global enable. While it is 1, every counter adds 1 on each clock edge where its selected condition input is 1. While it is 0, every counter holds.
- R5: The config register holds the selected counter's condition number. Condition k counts the input bit k, and condition 0 never fires. Config reads back the value written.
- R6: Writing 1 to control bit 17 copies the selected counter's full value, as it stands before that edge, into the snapshot low/high pair (0x252/0x253) in one clock.
- R7: Writing 1 to control bit 16 sets every counter to zero at that edge.
- R8: A write to count low replaces bits [31:0] of the selected counter, and a write to count high replaces its upper bits. Such a write wins over an increment in the same cycle.
- R9: The count carries from bit 31 into the high half and wraps to zero when all bits are 1.
- R10: After reset, every register is 0. Control reads back only bit 0, so bits 31:1 read 0, including both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cond_in | input | NUM_COND | Per-cycle condition pulses, bit k is condition k |

## Verification
On every cycle, the assertions check the following:
- every counter holds while the enable is off;
- a parked counter (condition 0) never moves;
- a counter steps by at most one per edge unless software writes it;
- a clear strobe zeroes the bank;
- a snapshot strobe captures the pre-edge value of the indexed counter;
- control reads back no bit above bit 0.

Only the bench scenarios can show the rest:
- exact counts under mixed condition patterns;
- the carry from the low half into the high half, and the full wrap;
- a preload winning over a same-cycle increment;
- decoding through the index register, including an index out of range;
- the ASCII layout of the name words.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  typedef logic [11:0] aux_addr_t;

  localparam aux_addr_t A_CNT_LO   = 12'h250;
  localparam aux_addr_t A_CNT_HI   = 12'h251;
  localparam aux_addr_t A_SNAP_LO  = 12'h252;
  localparam aux_addr_t A_SNAP_HI  = 12'h253;
  localparam aux_addr_t A_CFG      = 12'h254;
  localparam aux_addr_t A_CTRL     = 12'h255;
  localparam aux_addr_t A_CIDX     = 12'h256;
  localparam aux_addr_t A_CTR_BLD  = 12'h0F5;
  localparam aux_addr_t A_COND_BLD = 12'h0F6;
  localparam aux_addr_t A_NIDX     = 12'h240;
  localparam aux_addr_t A_NAME0    = 12'h241;
  localparam aux_addr_t A_NAME1    = 12'h242;

  localparam int RUN_BIT  = 0;
  localparam int CLR_BIT  = 16;
  localparam int SNAP_BIT = 17;
endpackage

// File: rtl/evctr_cond_sel.sv
module evctr_cond_sel #(
  parameter int NUM_COND = 16,
  parameter int COND_W   = 4
) (
  input  logic [NUM_COND-1:0] cond_in,
  input  logic [COND_W-1:0]   sel,
  output logic                hit
);
  localparam logic [COND_W:0] LIMIT = (COND_W+1)'(NUM_COND);

  // Code 0 is the parked selector; codes past the input vector never fire.
  always_comb begin
    hit = 1'b0;
    if (sel != '0 && {1'b0, sel} < LIMIT)
      hit = cond_in[sel];
  end
endmodule

// File: rtl/evctr_counter.sv
module evctr_counter #(
  parameter int NUM_COND = 16,
  parameter int COND_W   = 4,
  parameter int CTR_W    = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [NUM_COND-1:0] cond_in,
  input  logic                clr,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic                cfg_we,
  input  logic [31:0]         wdata,
  output logic [CTR_W-1:0]    value,
  output logic [COND_W-1:0]   cfg
);
  localparam int HI_W = CTR_W - 32;
  localparam logic [CTR_W-1:0] ONE = {{(CTR_W-1){1'b0}}, 1'b1};

  logic hit;

  evctr_cond_sel #(.NUM_COND(NUM_COND), .COND_W(COND_W)) u_sel (
    .cond_in (cond_in),
    .sel     (cfg),
    .hit     (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      cfg   <= '0;
    end else begin
      if (cfg_we)
        cfg <= wdata[COND_W-1:0];
      if (clr)
        value <= '0;
      else if (lo_we)
        value[31:0] <= wdata;
      else if (hi_we)
        value[CTR_W-1:32] <= wdata[HI_W-1:0];
      else if (run_en && hit)
        value <= value + ONE;
    end
  end
endmodule

// File: rtl/evctr_name_rom.sv
module evctr_name_rom #(
  parameter int NUM_COND = 16
) (
  input  logic [7:0]  idx,
  output logic [31:0] word0,
  output logic [31:0] word1
);
  localparam logic [8:0] LIMIT = 9'(NUM_COND);

  logic [7:0] tens;
  logic [7:0] units;

  // Name is "evt" + two decimal digits, NUL padded; character 0 in the low byte.
  always_comb begin
    tens  = idx / 8'd10;
    units = idx % 8'd10;
    word0 = '0;
    word1 = '0;
    if ({1'b0, idx} < LIMIT) begin
      word0 = {8'h30 + tens, 8'h74, 8'h76, 8'h65};
      word1 = {24'h0, 8'h30 + units};
    end
  end
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
  import evctr_pkg::*;
#(
  parameter int         NUM_CTR   = 4,
  parameter int         SIZE_CODE = 1,
  parameter int         NUM_COND  = 16,
  parameter logic [7:0] VERSION   = 8'h01,
  parameter logic [7:0] EXT_FIELD = 8'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_COND-1:0] cond_in
);
  localparam int CTR_W  = 32 + 16 * SIZE_CODE;
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam int COND_W = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;
  localparam logic [8:0] CTR_LIMIT = 9'(NUM_CTR);
  localparam logic [31:0] CTR_BUILD =
    {EXT_FIELD, 8'(NUM_CTR), 6'b0, 2'(SIZE_CODE), VERSION};
  localparam logic [31:0] COND_BUILD = {16'(NUM_COND), 8'h00, VERSION};

  logic [7:0]                    ctr_idx;
  logic [7:0]                    cond_idx;
  logic                          run_en;
  logic [CTR_W-1:0]              snap;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_val;
  logic [NUM_CTR-1:0][COND_W-1:0] ctr_cfg;

  logic             idx_ok;
  logic [IDX_W-1:0] sel;
  logic [CTR_W-1:0] sel_val;
  logic [COND_W-1:0] sel_cfg;
  logic wr_lo, wr_hi, wr_cfg, wr_ctrl, wr_cidx, wr_nidx;
  logic clr_all, take_snap;
  logic [31:0] name_w0, name_w1;

  assign idx_ok  = {1'b0, ctr_idx} < CTR_LIMIT;
  assign sel     = ctr_idx[IDX_W-1:0];
  assign sel_val = idx_ok ? ctr_val[sel] : '0;
  assign sel_cfg = idx_ok ? ctr_cfg[sel] : '0;

  assign wr_lo     = bus_we && (bus_addr == A_CNT_LO);
  assign wr_hi     = bus_we && (bus_addr == A_CNT_HI);
  assign wr_cfg    = bus_we && (bus_addr == A_CFG);
  assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
  assign wr_cidx   = bus_we && (bus_addr == A_CIDX);
  assign wr_nidx   = bus_we && (bus_addr == A_NIDX);
  assign clr_all   = wr_ctrl && bus_wdata[CLR_BIT];
  assign take_snap = wr_ctrl && bus_wdata[SNAP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_idx  <= '0;
      cond_idx <= '0;
      run_en   <= 1'b0;
      snap     <= '0;
    end else begin
      if (wr_cidx) ctr_idx <= bus_wdata[7:0];
      if (wr_nidx) cond_idx <= bus_wdata[7:0];
      if (wr_ctrl) run_en <= bus_wdata[RUN_BIT];
      if (take_snap) snap <= sel_val;
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic hit_me;
    assign hit_me = idx_ok && (sel == IDX_W'(i));

    evctr_counter #(
      .NUM_COND (NUM_COND),
      .COND_W   (COND_W),
      .CTR_W    (CTR_W)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .cond_in (cond_in),
      .clr     (clr_all),
      .lo_we   (wr_lo && hit_me),
      .hi_we   (wr_hi && hit_me),
      .cfg_we  (wr_cfg && hit_me),
      .wdata   (bus_wdata),
      .value   (ctr_val[i]),
      .cfg     (ctr_cfg[i])
    );
  end

  evctr_name_rom #(.NUM_COND(NUM_COND)) u_names (
    .idx   (cond_idx),
    .word0 (name_w0),
    .word1 (name_w1)
  );

  always_comb begin
    unique case (bus_addr)
      A_CNT_LO:   bus_rdata = sel_val[31:0];
      A_CNT_HI:   bus_rdata = 32'(sel_val[CTR_W-1:32]);
      A_SNAP_LO:  bus_rdata = snap[31:0];
      A_SNAP_HI:  bus_rdata = 32'(snap[CTR_W-1:32]);
      A_CFG:      bus_rdata = 32'(sel_cfg);
      A_CTRL:     bus_rdata = {31'b0, run_en};
      A_CIDX:     bus_rdata = {24'b0, ctr_idx};
      A_CTR_BLD:  bus_rdata = CTR_BUILD;
      A_COND_BLD: bus_rdata = COND_BUILD;
      A_NIDX:     bus_rdata = {24'b0, cond_idx};
      A_NAME0:    bus_rdata = name_w0;
      A_NAME1:    bus_rdata = name_w1;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evctr_unit_chk.sv
module evctr_unit_chk
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int COND_W  = 4,
  parameter int IDX_W   = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_we,
  input logic [11:0]                    bus_addr,
  input logic [31:0]                    bus_wdata,
  input logic [31:0]                    bus_rdata,
  input logic                           run_en,
  input logic [7:0]                     ctr_idx,
  input logic [CTR_W-1:0]               snap,
  input logic [NUM_CTR-1:0][CTR_W-1:0]  ctr_val,
  input logic [NUM_CTR-1:0][COND_W-1:0] ctr_cfg
);
  localparam logic [8:0] CTR_LIMIT = 9'(NUM_CTR);

  logic             sw_touch;
  logic [CTR_W-1:0] cur_val;

  assign sw_touch = bus_we && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI ||
                               bus_addr == A_CTRL);
  assign cur_val  = ({1'b0, ctr_idx} < CTR_LIMIT) ? ctr_val[ctr_idx[IDX_W-1:0]] : '0;

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !sw_touch) |=> $stable(ctr_val));

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL && bus_wdata[CLR_BIT]) |=> (ctr_val == '0));

  // R6
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL && bus_wdata[SNAP_BIT]) |=> (snap == $past(cur_val)));

  // R10
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[31:1] == '0));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_each
    // R5
    parked_never_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_cfg[i] == '0 && !sw_touch) |=> $stable(ctr_val[i]));

    // R9
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_touch |=> (ctr_val[i] == $past(ctr_val[i]) ||
                     ctr_val[i] == $past(ctr_val[i]) + {{(CTR_W-1){1'b0}}, 1'b1}));
  end
endmodule

bind evctr_unit evctr_unit_chk #(
  .NUM_CTR (NUM_CTR),
  .CTR_W   (CTR_W),
  .COND_W  (COND_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .run_en    (run_en),
  .ctr_idx   (ctr_idx),
  .snap      (snap),
  .ctr_val   (ctr_val),
  .ctr_cfg   (ctr_cfg)
);

// File: tb/evctr_unit_tb.sv
module evctr_unit_tb;
  localparam int NUM_COND = 16;
  localparam time PERIOD  = 20ns;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                bus_we = 1'b0;
  logic [11:0]         bus_addr = '0;
  logic [31:0]         bus_wdata = '0;
  logic [31:0]         bus_rdata;
  logic [NUM_COND-1:0] cond_in = '0;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  item_t sb_q[$];

  always #(PERIOD/2) clk = ~clk;

  evctr_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cond_in   (cond_in)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  // Driver: put the address on the port and queue the expected data.
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic pulse(input logic [NUM_COND-1:0] p, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cond_in = p;
    end
    @(posedge clk);
    #1 cond_in = '0;
  endtask

  // Monitor: compare mid-low-phase, away from any edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(12'h255, 32'h0, "R10 ctrl after reset");
    rd(12'h256, 32'h0, "R10 index after reset");
    rd(12'h250, 32'h0, "R10 count after reset");
    // R1 build words
    rd(12'h0F5, 32'h0004_0101, "R1 counter build");
    rd(12'h0F6, 32'h0010_0001, "R1 condition build");

    // R5 condition selection: ctr0->3, ctr1->0 (never), ctr2->7, ctr3->3
    wr(12'h256, 0); wr(12'h254, 3);
    wr(12'h256, 1); wr(12'h254, 0);
    wr(12'h256, 2); wr(12'h254, 7);
    wr(12'h256, 3); wr(12'h254, 3);
    rd(12'h256, 32'h3, "R3 index readback");
    wr(12'h256, 2);
    rd(12'h254, 32'h7, "R5 config readback");

    // R4 counting while enabled
    wr(12'h255, 32'h1);
    pulse(16'hFFFF, 10);
    pulse(16'h0008, 5);
    wr(12'h255, 32'h0);
    wr(12'h256, 0); rd(12'h250, 32'd15, "R4 ctr0 count");
    rd(12'h251, 32'd0, "R4 ctr0 high");
    wr(12'h256, 1); rd(12'h250, 32'd0, "R5 never condition");
    wr(12'h256, 2); rd(12'h250, 32'd10, "R3 ctr2 count");
    wr(12'h256, 3); rd(12'h250, 32'd15, "R3 ctr3 count");

    // R4 hold while disabled
    pulse(16'hFFFF, 4);
    wr(12'h256, 2); rd(12'h250, 32'd10, "R4 hold when off");

    // R6 snapshot of ctr0
    wr(12'h256, 0);
    wr(12'h255, 32'h0002_0000);
    rd(12'h252, 32'd15, "R6 snapshot low");
    rd(12'h253, 32'd0, "R6 snapshot high");
    rd(12'h255, 32'h0, "R10 strobes read 0");

    // R9 carry into high half
    wr(12'h256, 3);
    wr(12'h250, 32'hFFFF_FFFE); wr(12'h251, 32'h0);
    wr(12'h255, 32'h1);
    pulse(16'h0008, 3);
    wr(12'h255, 32'h0);
    rd(12'h250, 32'd1, "R9 carry low");
    rd(12'h251, 32'd1, "R9 carry high");
    wr(12'h255, 32'h0002_0000);
    rd(12'h252, 32'd1, "R6 wide snapshot low");
    rd(12'h253, 32'd1, "R6 wide snapshot high");

    // R9 full wrap
    wr(12'h250, 32'hFFFF_FFFF); wr(12'h251, 32'h0000_FFFF);
    rd(12'h251, 32'h0000_FFFF, "R8 high preload");
    wr(12'h255, 32'h1);
    pulse(16'h0008, 2);
    wr(12'h255, 32'h0);
    rd(12'h250, 32'd1, "R9 wrap low");
    rd(12'h251, 32'd0, "R9 wrap high");

    // R8 write beats increment in same cycle
    wr(12'h256, 0);
    wr(12'h255, 32'h1);
    @(negedge clk); cond_in = 16'h0008;
    wr(12'h250, 32'd100);
    cond_in = '0;
    wr(12'h255, 32'h0);
    rd(12'h250, 32'd100, "R8 write over increment");

    // R3 out-of-range index
    wr(12'h256, 9);
    wr(12'h250, 32'd55);
    rd(12'h250, 32'd0, "R3 out-of-range index");
    rd(12'h256, 32'd9, "R3 index stores 8 bits");

    // R7 clear all (enable kept on, strobe reads 0)
    wr(12'h255, 32'h0001_0001);
    wr(12'h255, 32'h0);
    wr(12'h256, 2); rd(12'h250, 32'd0, "R7 ctr2 cleared");
    wr(12'h256, 0); rd(12'h250, 32'd0, "R7 ctr0 cleared");
    wr(12'h256, 3); rd(12'h251, 32'd0, "R7 ctr3 high cleared");
    wr(12'h255, 32'h0003_0001);
    rd(12'h255, 32'h1, "R10 ctrl reads only enable");
    wr(12'h255, 32'h0);

    // R2 name table
    wr(12'h240, 5);
    rd(12'h241, 32'h3074_7665, "R2 name 5 word0");
    rd(12'h242, 32'h0000_0035, "R2 name 5 word1");
    wr(12'h240, 12);
    rd(12'h241, 32'h3174_7665, "R2 name 12 word0");
    rd(12'h242, 32'h0000_0032, "R2 name 12 word1");
    wr(12'h240, 20);
    rd(12'h241, 32'h0, "R2 name out of range");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule